// File: doc/BRIEF.md
# I2C Converter Register Slave

This block is the two-wire serial slave of a small data converter. It watches an oversampled clock line and data line from the bus. It pulls the data line low through an open-drain enable and never touches the clock line. A master can read the 16-bit conversion result and then the 8-bit configuration byte, or it can write a new configuration byte. The configuration fields go to a separate conversion controller as plain outputs. The slave also answers the general-call address, where one data code resets the converter's settings. It recognises the high-speed master code and flags high-speed operation without ever acknowledging that code.

The 7-bit slave address is the fixed prefix `1001` followed by a 3-bit instance parameter. The start and stop conditions are detected on a system clock that runs at least eight times faster than the bus clock. Every reply bit changes only after a falling edge of the bus clock.

Top module: `i2c_cnv_slave`

## Requirements
- R1: After reset the data line is released, high-speed mode is off, and the configuration is continuous mode (single=0), rate code 3 and gain code 0. Read back, that configuration is the byte 8CH.
- R2: An address byte whose upper 7 bits equal {1001, ADDR_LO} is acknowledged. Bit 0 of the address byte selects read (1) or write (0). Any other address that is not a general call is not acknowledged, and the slave stays silent until the next start or stop.
- R3: A read returns the result high byte, then the result low byte, then the configuration byte. The configuration byte has bit7 = status, bits 6:5 = 0, bit4 = single, bits 3:2 = rate and bits 1:0 = gain. The status bit is 1 in continuous mode and equals busy_i in single mode.
- R4: In a read, every byte after the configuration byte is FFH.
- R5: The result word is captured when the first read byte is loaded. A change of result_i during the read does not affect the low byte of that read.
- R6: The first data byte of a write is acknowledged and loads single, rate and gain from its bits 4:0. Its bits 6:5 are ignored. Later bytes of the same write are not acknowledged and change nothing.
- R7: A written byte with bit7=1 and bit4=1 produces a one-cycle cfg_start pulse when busy_i is 0. The pulse does not occur when busy_i is 1 or when the written byte selects continuous mode.
- R8: The general-call address 00H is acknowledged. Data 06H is acknowledged, pulses gc_reset and returns the configuration to its reset value. Data 04H is acknowledged and changes nothing. Any other data byte is not acknowledged.
- R9: An address byte 00001xxx is never acknowledged and sets hs_mode. hs_mode clears at the next stop.
- R10: A start during a transfer, including one in the middle of a byte, discards the partial byte and decodes the next byte as a fresh address with the reply byte count restarted.
- R11: sda_oe changes only after a detected falling edge of the bus clock, a start or a stop. It never changes while the bus clock is steadily high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as sensed |
| sda_i | input | 1 | Bus data line as sensed |
| sda_oe | output | 1 | 1 pulls the data line low |
| result_i | input | RES_W | Latest conversion result, two's complement |
| busy_i | input | 1 | Conversion in progress |
| cfg_single | output | 1 | 1 = single-conversion mode |
| cfg_rate | output | 2 | Data-rate code |
| cfg_gain | output | 2 | Gain code |
| cfg_start | output | 1 | One-cycle request to start a single conversion |
| gc_reset | output | 1 | One-cycle general-call reset pulse |
| hs_mode | output | 1 | High-speed master code seen since last stop |

## Verification
The bench builds the slave with ADDR_LO = 101, so the address match depends on a non-zero instance field. That setting also keeps address 1001000 as a foreign address that must not be acknowledged. The bench keeps RES_W at 16 and SYNC_STAGES at 2, and it runs the bus clock at one fortieth of the system clock. With these values the bench reaches the reply-byte saturation into FFH and a read that is interrupted mid-byte by a start.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_RX_ACK, S_TX, S_TX_ACK, S_IGNORE
  } slv_state_t;

  typedef enum logic [1:0] {
    K_ADDR, K_WRITE, K_GCALL, K_READ
  } byte_kind_t;

  typedef struct packed {
    logic       single;
    logic [1:0] rate;
    logic [1:0] gain;
  } cfg_t;

  localparam logic [3:0] ADDR_PREFIX  = 4'b1001;
  localparam logic [4:0] HS_PREFIX    = 5'b00001;
  localparam logic [7:0] GC_RESET_CMD = 8'h06;
  localparam logic [7:0] GC_NOP_CMD   = 8'h04;
  localparam cfg_t       CFG_RESET    = '{single: 1'b0, rate: 2'b11, gain: 2'b00};
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_s, scl_q, sda_q;

  i2cs_sync #(.STAGES(SYNC_STAGES)) u_scl (.clk(clk), .rst(rst), .d(scl_raw), .q(scl_s));
  i2cs_sync #(.STAGES(SYNC_STAGES)) u_sda (.clk(clk), .rst(rst), .d(sda_raw), .q(sda_s));

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  // R10/R11: data edges while the clock stays high are bus conditions
  assign scl_rise  =  scl_s & ~scl_q;
  assign scl_fall  = ~scl_s &  scl_q;
  assign start_evt =  scl_s &  scl_q &  sda_q & ~sda_s;
  assign stop_evt  =  scl_s &  scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/i2cs_cfg_reg.sv
module i2cs_cfg_reg
  import i2cs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       wr_go,
  input  logic [4:0] wr_fields,
  input  logic       gc_req,
  input  logic       busy_i,
  output cfg_t       cfg,
  output logic       start_pulse,
  output logic [7:0] rd_byte
);
  always_ff @(posedge clk) begin
    if (rst || gc_req) begin          // R1, R8
      cfg         <= CFG_RESET;
      start_pulse <= 1'b0;
    end else if (wr_en) begin         // R6, R7
      cfg         <= cfg_t'(wr_fields);
      start_pulse <= wr_go & wr_fields[4] & ~busy_i;
    end else begin
      start_pulse <= 1'b0;
    end
  end

  // R3: status bit reads 1 in continuous mode
  assign rd_byte = {(cfg.single ? busy_i : 1'b1), 2'b00, cfg};
endmodule

// File: rtl/i2c_cnv_slave.sv
module i2c_cnv_slave
  import i2cs_pkg::*;
#(
  parameter logic [2:0] ADDR_LO     = 3'b000,
  parameter int         SYNC_STAGES = 2,
  parameter int         RES_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [RES_W-1:0] result_i,
  input  logic             busy_i,
  output logic             cfg_single,
  output logic [1:0]       cfg_rate,
  output logic [1:0]       cfg_gain,
  output logic             cfg_start,
  output logic             gc_reset,
  output logic             hs_mode
);
  localparam int RES_BYTES = RES_W / 8;
  localparam int IDX_W     = $clog2(RES_BYTES + 2);
  localparam int REPLY_N   = 2 ** IDX_W;
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(RES_BYTES + 1);
  localparam logic [6:0] MY_ADDR = {ADDR_PREFIX, ADDR_LO};

  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  i2cs_bus_events #(.SYNC_STAGES(SYNC_STAGES)) u_ev (
    .clk(clk), .rst(rst), .scl_raw(scl_i), .sda_raw(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  slv_state_t       state, rx_next;
  byte_kind_t       kind;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg, txb;
  logic [IDX_W-1:0] byte_idx;
  logic [RES_W-1:0] res_q;
  logic             oe_q, hs_q, gc_q, master_ack;

  cfg_t       cfg;
  logic [7:0] cfg_rd;

  // Decision made on the falling edge that ends the eighth received bit
  logic       byte_done, ack_now, wr_stb, gc_stb, hs_set;
  slv_state_t nxt_state;
  byte_kind_t nxt_kind;

  always_comb begin
    byte_done = (state == S_RX) && scl_fall && (bitcnt == 4'd8);
    ack_now   = 1'b0;
    nxt_state = S_IGNORE;
    nxt_kind  = kind;
    hs_set    = 1'b0;
    unique case (kind)
      K_ADDR: begin
        if (shreg[7:3] == HS_PREFIX) begin          // R9
          hs_set = 1'b1;
        end else if (shreg[7:1] == MY_ADDR) begin   // R2
          ack_now   = 1'b1;
          nxt_state = shreg[0] ? S_TX : S_RX;
          nxt_kind  = shreg[0] ? K_READ : K_WRITE;
        end else if (shreg == 8'h00) begin          // R8
          ack_now   = 1'b1;
          nxt_state = S_RX;
          nxt_kind  = K_GCALL;
        end
      end
      K_WRITE: begin                                // R6
        ack_now   = (byte_idx == '0);
        nxt_state = S_RX;
      end
      K_GCALL: begin
        ack_now   = (shreg == GC_RESET_CMD) || (shreg == GC_NOP_CMD);
        nxt_state = S_RX;
      end
      default: ;
    endcase
    hs_set = hs_set && byte_done;
    wr_stb = byte_done && (kind == K_WRITE) && (byte_idx == '0);
    gc_stb = byte_done && (kind == K_GCALL) && (shreg == GC_RESET_CMD);
  end

  i2cs_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_stb), .wr_go(shreg[7]),
    .wr_fields(shreg[4:0]), .gc_req(gc_stb), .busy_i(busy_i),
    .cfg(cfg), .start_pulse(cfg_start), .rd_byte(cfg_rd)
  );

  // R3, R4: reply table, result bytes MSB first, then config, then FFH
  logic [7:0] reply [REPLY_N];
  genvar g;
  generate
    for (g = 0; g < REPLY_N; g++) begin : g_reply
      if (g < RES_BYTES) begin : g_res
        assign reply[g] = res_q[RES_W-1-8*g -: 8];
      end else if (g == RES_BYTES) begin : g_cfg
        assign reply[g] = cfg_rd;
      end else begin : g_pad
        assign reply[g] = 8'hFF;
      end
    end
  endgenerate

  logic [7:0] first_byte;
  assign first_byte = result_i[RES_W-1 -: 8];

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      rx_next    <= S_IDLE;
      kind       <= K_ADDR;
      bitcnt     <= '0;
      shreg      <= '0;
      txb        <= '1;
      byte_idx   <= '0;
      res_q      <= '0;
      oe_q       <= 1'b0;
      hs_q       <= 1'b0;
      gc_q       <= 1'b0;
      master_ack <= 1'b0;
    end else begin
      gc_q <= gc_stb;
      if (stop_evt) begin                      // R9, R11
        state <= S_IDLE;
        oe_q  <= 1'b0;
        hs_q  <= 1'b0;
      end else if (start_evt) begin            // R10
        state    <= S_RX;
        kind     <= K_ADDR;
        bitcnt   <= '0;
        byte_idx <= '0;
        oe_q     <= 1'b0;
      end else begin
        unique case (state)
          S_RX: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_done) begin
              oe_q    <= ack_now;
              state   <= S_RX_ACK;
              rx_next <= nxt_state;
              kind    <= nxt_kind;
              if (hs_set) hs_q <= 1'b1;
              if (kind == K_WRITE && byte_idx != IDX_MAX)
                byte_idx <= byte_idx + 1'b1;
            end
          end
          S_RX_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              state  <= rx_next;
              if (rx_next == S_TX) begin       // R5: capture whole word
                res_q    <= result_i;
                txb      <= first_byte;
                oe_q     <= ~first_byte[7];
                byte_idx <= IDX_W'(1);
              end else begin
                oe_q <= 1'b0;
              end
            end
          end
          S_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                oe_q  <= 1'b0;
                state <= S_TX_ACK;
              end else begin
                oe_q <= ~txb[6];
                txb  <= {txb[6:0], 1'b1};
              end
            end
          end
          S_TX_ACK: begin
            if (scl_rise) begin
              master_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (master_ack) begin
                txb    <= reply[byte_idx];
                oe_q   <= ~reply[byte_idx][7];
                bitcnt <= '0;
                state  <= S_TX;
                if (byte_idx != IDX_MAX) byte_idx <= byte_idx + 1'b1;
              end else begin
                state <= S_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe     = oe_q;
  assign hs_mode    = hs_q;
  assign gc_reset   = gc_q;
  assign cfg_single = cfg.single;
  assign cfg_rate   = cfg.rate;
  assign cfg_gain   = cfg.gain;
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
  input logic       clk,
  input logic       rst,
  input logic       scl_fall,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       sda_oe,
  input logic       hs_mode,
  input logic       cfg_start,
  input logic       cfg_single,
  input logic [1:0] cfg_rate,
  input logic [1:0] cfg_gain,
  input logic       gc_reset
);
  // R11: data enable moves only after a clock fall, start or stop
  a_r11_sda_changes_on_fall: assert property (@(posedge clk) disable iff (rst)
    (!$past(scl_fall) && !$past(start_evt) && !$past(stop_evt)) |-> $stable(sda_oe));

  // R9: leaving the bus on stop, high-speed flag cleared
  a_r9_stop_clears_hs: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> (!sda_oe && !hs_mode));

  // R9: master code never acknowledged
  a_r9_hs_code_no_ack: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_mode) |-> !sda_oe);

  // R7: start request only alongside single mode
  a_r7_start_needs_single: assert property (@(posedge clk) disable iff (rst)
    cfg_start |-> cfg_single);

  // R8: reset pulse comes with default settings and lasts one cycle
  a_r8_gc_defaults: assert property (@(posedge clk) disable iff (rst)
    gc_reset |-> (!cfg_single && cfg_rate == 2'b11 && cfg_gain == 2'b00 && !cfg_start));

  a_r8_gc_single_cycle: assert property (@(posedge clk) disable iff (rst)
    gc_reset |=> !gc_reset);
endmodule

bind i2c_cnv_slave i2cs_checker u_chk (
  .clk(clk), .rst(rst), .scl_fall(scl_fall), .start_evt(start_evt),
  .stop_evt(stop_evt), .sda_oe(sda_oe), .hs_mode(hs_mode),
  .cfg_start(cfg_start), .cfg_single(cfg_single), .cfg_rate(cfg_rate),
  .cfg_gain(cfg_gain), .gc_reset(gc_reset)
);

// File: tb/test_i2c_cnv_slave.sv
module test_i2c_cnv_slave;
  localparam int QP = 10;
  localparam logic [2:0] LO = 3'b101;
  localparam logic [6:0] MY = {4'b1001, LO};
  localparam logic [7:0] A_WR = {MY, 1'b0};
  localparam logic [7:0] A_RD = {MY, 1'b1};

  logic clk = 1'b0, rst = 1'b1, scl_m = 1'b1, sda_m = 1'b1;
  logic [15:0] result = 16'h0000;
  logic busy = 1'b0;
  logic sda_oe, cfg_single, cfg_start, gc_reset, hs_mode;
  logic [1:0] cfg_rate, cfg_gain;
  wire sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  i2c_cnv_slave #(.ADDR_LO(LO), .SYNC_STAGES(2), .RES_W(16)) i_i2c_cnv_slave (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .result_i(result), .busy_i(busy), .cfg_single(cfg_single),
    .cfg_rate(cfg_rate), .cfg_gain(cfg_gain), .cfg_start(cfg_start),
    .gc_reset(gc_reset), .hs_mode(hs_mode)
  );

  int total = 0, bad = 0;
  int starts = 0, gcs = 0, r11_viol = 0, hi_cnt = 0;
  bit done = 0, mdl_on = 0;
  logic prev_oe = 1'b0;
  // behavioural model of the configuration register
  int m_single = 0, m_rate = 3, m_gain = 0;

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison with the model while the bus is idle
  always @(negedge clk) begin
    if (!rst) begin
      if (cfg_start) starts++;
      if (gc_reset)  gcs++;
      if (scl_m) hi_cnt++; else hi_cnt = 0;
      if (hi_cnt > 6 && sda_oe !== prev_oe) r11_viol++;
      prev_oe = sda_oe;
      if (mdl_on) begin
        check("R6 model single", int'(cfg_single), m_single);
        check("R6 model rate", int'(cfg_rate), m_rate);
        check("R6 model gain", int'(cfg_gain), m_gain);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    mdl_on = 0;
    sda_m = 1; tick(QP); scl_m = 1; tick(QP);
    sda_m = 0; tick(QP); scl_m = 0; tick(QP);
  endtask

  task automatic bus_stop();
    sda_m = 0; tick(QP); scl_m = 1; tick(QP); sda_m = 1; tick(2*QP);
    mdl_on = 1;
  endtask

  task automatic put_bit(logic b);
    sda_m = b; tick(QP); scl_m = 1; tick(2*QP); scl_m = 0; tick(QP);
  endtask

  task automatic wr_byte(logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1; tick(QP); scl_m = 1; tick(QP);
    acked = !sda_line;
    tick(QP); scl_m = 0; tick(QP);
  endtask

  task automatic rd_byte(bit mack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 0; i < 8; i++) begin
      tick(QP); scl_m = 1; tick(QP);
      b = {b[6:0], sda_line};
      tick(QP); scl_m = 0; tick(QP);
    end
    put_bit(mack ? 1'b0 : 1'b1);
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    bit ak;
    logic [7:0] b;
    int s0;
    tick(5); rst = 0; tick(5);
    // R1 reset state
    check("R1 sda_oe", int'(sda_oe), 0);
    check("R1 hs_mode", int'(hs_mode), 0);
    check("R1 single", int'(cfg_single), 0);
    check("R1 rate", int'(cfg_rate), 3);
    check("R1 gain", int'(cfg_gain), 0);
    mdl_on = 1;

    // R3/R4 read in continuous mode
    result = 16'hA5C3;
    bus_start(); wr_byte(A_RD, ak); check("R2 read address ack", int'(ak), 1);
    rd_byte(1, b); check("R3 high byte", b, 8'hA5);
    rd_byte(1, b); check("R3 low byte", b, 8'hC3);
    rd_byte(1, b); check("R1 R3 config byte default", b, 8'h8C);
    rd_byte(1, b); check("R4 fourth byte", b, 8'hFF);
    rd_byte(0, b); check("R4 fifth byte", b, 8'hFF);
    bus_stop();

    // R2 foreign address ignored
    bus_start(); wr_byte(8'h90, ak); check("R2 foreign address nack", int'(ak), 0);
    wr_byte(8'h13, ak); check("R2 silent after foreign", int'(ak), 0);
    bus_stop();

    // R6 write: first byte taken, reserved ignored, later byte refused
    bus_start(); wr_byte(A_WR, ak); check("R2 write address ack", int'(ak), 1);
    wr_byte(8'h7E, ak); check("R6 first byte ack", int'(ak), 1);
    m_single = 1; m_rate = 3; m_gain = 2;
    wr_byte(8'h00, ak); check("R6 second byte nack", int'(ak), 0);
    bus_stop();
    check("R7 no start for bit7=0", starts, 0);

    // R3 status bit in single mode
    busy = 0;
    bus_start(); wr_byte(A_RD, ak); rd_byte(1, b); rd_byte(1, b);
    rd_byte(0, b); bus_stop(); check("R3 single idle cfg", b, 8'h1E);
    busy = 1;
    bus_start(); wr_byte(A_RD, ak); rd_byte(1, b); rd_byte(1, b);
    rd_byte(0, b); bus_stop(); check("R3 single busy cfg", b, 8'h9E);

    // R7 start request
    busy = 0; s0 = starts;
    bus_start(); wr_byte(A_WR, ak); wr_byte(8'h91, ak); bus_stop();
    m_single = 1; m_rate = 0; m_gain = 1;
    check("R7 start pulse when idle", starts - s0, 1);
    busy = 1; s0 = starts;
    bus_start(); wr_byte(A_WR, ak); wr_byte(8'h92, ak); bus_stop();
    m_gain = 2;
    check("R7 no pulse when busy", starts - s0, 0);
    busy = 0; s0 = starts;
    bus_start(); wr_byte(A_WR, ak); wr_byte(8'h81, ak); bus_stop();
    m_single = 0; m_gain = 1;
    check("R7 no pulse in continuous", starts - s0, 0);

    // R5 coherent word
    result = 16'h1234;
    bus_start(); wr_byte(A_RD, ak); rd_byte(1, b); check("R5 high byte", b, 8'h12);
    result = 16'hABCD;
    rd_byte(0, b); check("R5 low byte from captured word", b, 8'h34);
    bus_stop();

    // R8 general call
    s0 = gcs;
    bus_start(); wr_byte(8'h00, ak); check("R8 gc address ack", int'(ak), 1);
    wr_byte(8'h04, ak); check("R8 data 04 ack", int'(ak), 1); bus_stop();
    check("R8 04 no reset", gcs - s0, 0);
    bus_start(); wr_byte(8'h00, ak); wr_byte(8'h05, ak);
    check("R8 data 05 nack", int'(ak), 0); bus_stop();
    bus_start(); wr_byte(8'h00, ak); wr_byte(8'h06, ak);
    check("R8 data 06 ack", int'(ak), 1); bus_stop();
    m_single = 0; m_rate = 3; m_gain = 0;
    check("R8 reset pulse", gcs - s0, 1);

    // R9 high-speed master code
    bus_start(); wr_byte(8'h09, ak); check("R9 master code nack", int'(ak), 0);
    check("R9 hs set", int'(hs_mode), 1);
    bus_start(); wr_byte(A_WR, ak); check("R9 R10 address after code", int'(ak), 1);
    check("R9 hs held", int'(hs_mode), 1);
    bus_stop(); check("R9 hs cleared by stop", int'(hs_mode), 0);

    // R10 start in mid-byte
    result = 16'h5AF0;
    bus_start(); wr_byte(A_WR, ak);
    put_bit(1); put_bit(1); put_bit(1);
    bus_start(); wr_byte(A_RD, ak); check("R10 address after broken byte", int'(ak), 1);
    rd_byte(1, b); check("R10 count restarts", b, 8'h5A);
    rd_byte(0, b); check("R10 low byte", b, 8'hF0);
    bus_stop();

    tick(20);
    check("R11 no sda change while clock high", r11_viol, 0);
    done = 1;
    report();
    $finish;
  end
endmodule